// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small processor and works out its next value on every edge of the core clock. The decoder supplies a three-bit flow code, a flag that says whether the current instruction is one or two words long, a signed 12-bit relative offset, an absolute target word and the 16-bit Z pointer. The unit picks the next address from these inputs and registers it. There is no clock divider and no stall, so the program counter moves on every cycle.

For call codes the unit also raises a push strobe and presents the return address in the same cycle. The return address is the address of the instruction after the call. The stack that stores it lives outside this block. Instruction memory and decoding are also outside it.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, the program counter `pc_o` is loaded with zero at each clock edge.
- R2: Flow codes 0 and 7 are sequential. The next `pc_o` is `pc_o` plus 1 when `two_word_i` is 0, and `pc_o` plus 2 when it is 1, modulo 2^PC_W.
- R3: Flow code 1 (absolute jump) and flow code 2 (absolute call) load `abs_tgt_i` into `pc_o` at the next edge.
- R4: Flow code 3 (indirect jump) and flow code 4 (indirect call) load `zptr_i` into `pc_o` at the next edge.
- R5: Flow code 5 (relative jump) and flow code 6 (relative call) set the next `pc_o` to `pc_o + k + 1` modulo 2^PC_W. Here `k` is `rel_ofs_i` read as 12-bit two's complement, with a range of -2048 to 2047.
- R6: `ret_push_o` is high in the same cycle exactly when the flow code is 2, 4 or 6, and low for every other code.
- R7: While `ret_push_o` is high, `ret_addr_o` equals `pc_o` + 2 for code 2, and `pc_o` + 1 for codes 4 and 6, modulo 2^PC_W.
- R8: `two_word_i` has no effect on the next `pc_o` for codes 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kind_i | input | 3 | Flow code (encoding given in R2 to R5) |
| two_word_i | input | 1 | Current instruction occupies two words |
| rel_ofs_i | input | 12 | Signed relative offset k |
| abs_tgt_i | input | 16 | Absolute target taken from the instruction |
| zptr_i | input | 16 | Z pointer register value |
| pc_o | output | 16 | Registered program counter |
| ret_addr_o | output | 16 | Return address for calls |
| ret_push_o | output | 1 | Return address must be pushed this cycle |

## Verification
A wrong next-address choice or an adder fault shows up at `pc_o` one edge after the flow code that exercised it. Because every later address is built on the registered value, the error then stays in the sequence from that point on. Faults in return generation show up at `ret_addr_o` and `ret_push_o` in the same cycle, with no wait for a clock edge. Sweeping every offset from a range of different bases exposes sign-extension and wrap faults the moment they are exercised.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

  typedef enum logic [2:0] {
    K_SEQ  = 3'd0,
    K_JABS = 3'd1,
    K_CABS = 3'd2,
    K_JIND = 3'd3,
    K_CIND = 3'd4,
    K_JREL = 3'd5,
    K_CREL = 3'd6,
    K_RSV  = 3'd7
  } pcn_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_ABS = 2'd1,
    SRC_IND = 2'd2,
    SRC_REL = 2'd3
  } pcn_src_e;

  typedef struct packed {
    pcn_src_e src;
    logic     call;
    logic     long_call;
  } pcn_ctrl_t;

endpackage

// File: rtl/pcn_decode.sv
module pcn_decode
  import pcn_pkg::*;
(
  input  logic [2:0] kind_i,
  output pcn_ctrl_t  ctrl_o
);

  pcn_kind_e kind;
  assign kind = pcn_kind_e'(kind_i);

  always_comb begin
    ctrl_o = '{src: SRC_SEQ, call: 1'b0, long_call: 1'b0};
    case (kind)
      K_JABS: ctrl_o.src = SRC_ABS;
      K_CABS: begin
        ctrl_o.src       = SRC_ABS;
        ctrl_o.call      = 1'b1;
        ctrl_o.long_call = 1'b1;
      end
      K_JIND: ctrl_o.src = SRC_IND;
      K_CIND: begin
        ctrl_o.src  = SRC_IND;
        ctrl_o.call = 1'b1;
      end
      K_JREL: ctrl_o.src = SRC_REL;
      K_CREL: begin
        ctrl_o.src  = SRC_REL;
        ctrl_o.call = 1'b1;
      end
      default: ctrl_o.src = SRC_SEQ;
    endcase
  end

endmodule

// File: rtl/pcn_arith.sv
module pcn_arith #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             two_word_i,
  input  logic             long_call_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  rel_o,
  output logic [PC_W-1:0]  ret_o
);

  logic [PC_W-1:0] ofs_ext;

  generate
    if (OFS_W < PC_W) begin : g_extend
      assign ofs_ext = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    end else begin : g_trunc
      assign ofs_ext = ofs_i[PC_W-1:0];
    end
  endgenerate

  function automatic logic [PC_W-1:0] add_step(input logic [PC_W-1:0] a, input logic two);
    logic [PC_W-1:0] step;
    step = two ? PC_W'(2) : PC_W'(1);
    return a + step;
  endfunction

  function automatic logic [PC_W-1:0] add_rel(input logic [PC_W-1:0] a, input logic [PC_W-1:0] k);
    return a + k + PC_W'(1);
  endfunction

  assign seq_o = add_step(pc_i, two_word_i);
  assign rel_o = add_rel(pc_i, ofs_ext);
  assign ret_o = add_step(pc_i, long_call_i);

endmodule

// File: rtl/pcn_select.sv
module pcn_select
  import pcn_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  pcn_src_e        src_i,
  input  logic [PC_W-1:0] seq_i,
  input  logic [PC_W-1:0] abs_i,
  input  logic [PC_W-1:0] ind_i,
  input  logic [PC_W-1:0] rel_i,
  output logic [PC_W-1:0] next_o
);

  always_comb begin
    case (src_i)
      SRC_ABS: next_o = abs_i;
      SRC_IND: next_o = ind_i;
      SRC_REL: next_o = rel_i;
      default: next_o = seq_i;
    endcase
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcn_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       kind_i,
  input  logic             two_word_i,
  input  logic [OFS_W-1:0] rel_ofs_i,
  input  logic [PC_W-1:0]  abs_tgt_i,
  input  logic [PC_W-1:0]  zptr_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  ret_addr_o,
  output logic             ret_push_o
);

  pcn_ctrl_t       ctrl;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_tgt;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] next_pc;
  logic            take_branch;

  pcn_decode u_dec (
    .kind_i (kind_i),
    .ctrl_o (ctrl)
  );

  pcn_arith #(.PC_W(PC_W), .OFS_W(OFS_W)) u_arith (
    .pc_i        (pc_q),
    .ofs_i       (rel_ofs_i),
    .two_word_i  (two_word_i),
    .long_call_i (ctrl.long_call),
    .seq_o       (seq_tgt),
    .rel_o       (rel_tgt),
    .ret_o       (ret_addr)
  );

  pcn_select #(.PC_W(PC_W)) u_sel (
    .src_i  (ctrl.src),
    .seq_i  (seq_tgt),
    .abs_i  (abs_tgt_i),
    .ind_i  (zptr_i),
    .rel_i  (rel_tgt),
    .next_o (next_pc)
  );

  assign take_branch = (ctrl.src != SRC_SEQ);

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= next_pc;
  end

  assign pc_o       = pc_q;
  assign ret_addr_o = ret_addr;
  assign ret_push_o = ctrl.call;

endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       kind_i,
  input logic             two_word_i,
  input logic [OFS_W-1:0] rel_ofs_i,
  input logic [PC_W-1:0]  abs_tgt_i,
  input logic [PC_W-1:0]  zptr_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [PC_W-1:0]  ret_addr_o,
  input logic             ret_push_o,
  input logic             take_branch
);

  logic [PC_W-1:0] k_ext;
  assign k_ext = PC_W'($signed(rel_ofs_i));

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> pc_o == '0); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == 3'd0 || kind_i == 3'd7) |=>
      pc_o == $past(pc_o) + ($past(two_word_i) ? PC_W'(2) : PC_W'(1))); // R2

  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == 3'd1 || kind_i == 3'd2) |=> pc_o == $past(abs_tgt_i)); // R3

  AST_IND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == 3'd3 || kind_i == 3'd4) |=> pc_o == $past(zptr_i)); // R4

  AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == 3'd5 || kind_i == 3'd6) |=> pc_o == $past(pc_o) + $past(k_ext) + PC_W'(1)); // R5

  AST_PUSH_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push_o |-> take_branch && !kind_i[0]); // R6

  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push_o |-> ret_addr_o == pc_o + ((kind_i == 3'd2) ? PC_W'(2) : PC_W'(1))); // R7

endmodule

bind pc_next_unit pc_next_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .kind_i      (kind_i),
  .two_word_i  (two_word_i),
  .rel_ofs_i   (rel_ofs_i),
  .abs_tgt_i   (abs_tgt_i),
  .zptr_i      (zptr_i),
  .pc_o        (pc_o),
  .ret_addr_o  (ret_addr_o),
  .ret_push_o  (ret_push_o),
  .take_branch (take_branch)
);

// File: tb/tb_pc_next_unit.sv
`timescale 1ns/1ps
module tb_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  kind_i = 3'd0;
  logic        two_word_i = 1'b0;
  logic [11:0] rel_ofs_i = '0;
  logic [15:0] abs_tgt_i = '0;
  logic [15:0] zptr_i = '0;
  logic [15:0] pc_o;
  logic [15:0] ret_addr_o;
  logic        ret_push_o;

  int n_run = 0;
  int n_fail = 0;
  int model_pc = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pc_next_unit dut (
    .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .two_word_i(two_word_i),
    .rel_ofs_i(rel_ofs_i), .abs_tgt_i(abs_tgt_i), .zptr_i(zptr_i),
    .pc_o(pc_o), .ret_addr_o(ret_addr_o), .ret_push_o(ret_push_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrap16(input int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  task automatic step(input int kind, input bit tw, input int ofs, input int abst, input int z);
    int k;
    int exp_pc;
    bit is_call;
    kind_i = kind[2:0]; two_word_i = tw; rel_ofs_i = ofs[11:0];
    abs_tgt_i = abst[15:0]; zptr_i = z[15:0];
    k = (ofs >= 2048) ? ofs - 4096 : ofs;
    #1;
    is_call = (kind == 2) || (kind == 4) || (kind == 6);
    check(is_call ? "R6 push on call" : "R6 no push", int'(ret_push_o), int'(is_call));
    if (kind == 2) check("R7 return after absolute call", int'(ret_addr_o), wrap16(model_pc + 2));
    if (kind == 4 || kind == 6) check("R7 return after short call", int'(ret_addr_o), wrap16(model_pc + 1));
    if (kind == 1 || kind == 2)      exp_pc = abst;
    else if (kind == 3 || kind == 4) exp_pc = z;
    else if (kind == 5 || kind == 6) exp_pc = wrap16(model_pc + k + 1);
    else                             exp_pc = wrap16(model_pc + (tw ? 2 : 1));
    @(posedge clk); #2;
    if (kind == 0 || kind == 7)      check("R2 sequential", int'(pc_o), exp_pc);
    else if (kind <= 2)              check("R3 absolute load / R8", int'(pc_o), exp_pc);
    else if (kind <= 4)              check("R4 indirect load / R8", int'(pc_o), exp_pc);
    else                             check("R5 relative target", int'(pc_o), exp_pc);
    model_pc = int'(pc_o);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset value", int'(pc_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_pc = 0;
    // R2 sequential steps and reserved code 7
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(7, 0, 0, 0, 0);
    step(7, 1, 0, 0, 0);
    // every code with both length flags: R8
    for (int kd = 0; kd < 8; kd++) begin
      for (int t = 0; t < 2; t++) begin
        step(1, 0, 0, 16'h4000 + kd * 16, 0);
        step(kd, bit'(t), 12'h7F3, 16'h1234 + kd, 16'hBEEF - kd);
      end
    end
    // near-exhaustive offset sweep: R5, R6, R7
    for (int o = 0; o < 4096; o++) begin
      step((o % 3 == 0) ? 4 : 1, 0, 0, wrap16(o * 97 + 300), wrap16(o * 131));
      step((o % 2 == 0) ? 5 : 6, bit'(o % 2), o, 16'hAAAA, 16'h5555);
    end
    // wrap corners
    step(1, 0, 0, 16'hFFFF, 0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 16'hFFFF, 0);
    step(0, 1, 0, 0, 0);
    step(2, 0, 0, 16'hFFFE, 0);
    step(2, 0, 0, 16'h0010, 0);
    step(3, 0, 0, 0, 16'h0000);
    step(5, 0, 12'hFFF, 0, 0);
    step(6, 0, 12'h800, 0, 0);
    step(3, 0, 0, 0, 16'hFFFF);
    step(6, 1, 12'h7FF, 0, 0);
    step(4, 0, 0, 0, 16'hFFFF);
    step(4, 0, 0, 0, 16'h0001);
    // reset mid-run
    rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1 reset during run", int'(pc_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_pc = 0;
    step(0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule